// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Register Bank

This block holds a small bank of interrupt mask and priority registers behind a simple write port and a combinational read port. Each mask register sits at two addresses. A write to the first sets the bits that are one in the data. A write to the second clears them. Each priority register sits at one address and takes the written value as it is.

Every field of every register is tied to one interrupt source id. After a write is accepted, the block compares the new value of each field with the old one. For each field that changed, it sends an enable or disable strobe for that source, one strobe per cycle. One priority field stands for a group: changing it sends the same strobe to each member of a fixed chain of sources, in chain order. While the strobes are being sent the block raises `busy`, and it refuses new writes until `busy` falls.

Top module: `scmask_bank`

## Requirements
- R1: A write to a mask register's set address (slot base + 0) stores the old value ORed with `wrData`.
- R2: A write to a mask register's clear address (slot base + 1) stores the old value ANDed with the inverse of `wrData`.
- R3: A write to a priority register's address (slot base + 0) stores `wrData` unchanged.
- R4: Register slots are 4 addresses apart. Slots 0 and 1 are mask registers and slot 2 is the priority register. `rdData` returns the stored value at the set address and also at the clear address. Any other address reads 0, and a write to it changes nothing and sends no strobe.
- R5: Field k is counted from the most significant end of the register. Mask fields are 1 bit wide and map to id = slot*8 + k + 1. Priority fields are 4 bits wide (2 per register) and map to ids 17 and 18. Changed fields are sent in ascending k.
- R6: A field whose value changed sends a strobe with `evtEnable`=1 if its new value is nonzero and 0 if it is zero. Unchanged fields send nothing. The first strobe is on the outputs in the cycle after the accepting edge.
- R7: Id 18 is a group. When its field changes, the group id itself is not sent. After one idle cycle the block sends ids 19, 20 and 21, one per cycle, each with the group field's enable value.
- R8: The least significant field of mask slot 1 maps to the reserved id 0. It stores its bit but never sends a strobe. No strobe ever carries id 0.
- R9: `busy` stays high while strobes are still to be sent. A write presented while `busy` is high is ignored.
- R10: After reset every register reads 0, and `busy` and `evtValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Write request |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Stored value at `rdAddr` (combinational) |
| busy | output | 1 | Strobe walk in progress; writes are refused |
| evtValid | output | 1 | A strobe is presented this cycle |
| evtEnable | output | 1 | 1 = enable, 0 = disable |
| evtId | output | 5 | Source id of the strobe |

## Verification
The new register value shows on `rdData` in the cycle after the accepting edge. The first strobe appears in that same cycle, and each later strobe follows one edge after the one before it. A group adds one silent cycle before its first member. The bench drives every write half a period before the edge that accepts it. It then reads the outputs at each following falling edge, records each strobe and stops when `busy` is low, so every strobe is seen in the cycle it is due. The test of an ignored write places the second write inside the busy window. It then checks both the register value and the total number of strobes.

// File: rtl/scmask_pkg.sv
package scmask_pkg;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_SET,
    KIND_CLR,
    KIND_DIRECT
  } accessKind_t;

  typedef struct packed {
    logic commit;
  } ctlStrobe_t;

endpackage

// File: rtl/scmask_regs.sv
module scmask_regs
  import scmask_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int FIELD_W  = 4,
  parameter int NUM_MREG = 2,
  parameter int NUM_PREG = 1,
  parameter int ADDR_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  output logic               wrHit,
  output logic               wrIsPrio,
  output logic [ADDR_W-3:0]  wrRegIdx,
  output logic [REG_W-1:0]   changed,
  output logic [REG_W-1:0]   fieldOn
);

  localparam int SLOT_W = ADDR_W - 2;
  localparam int NPF    = REG_W / FIELD_W;

  logic [REG_W-1:0] maskQ [NUM_MREG];
  logic [REG_W-1:0] prioQ [NUM_PREG];
  logic [REG_W-1:0] oldVal, nextVal;
  logic [SLOT_W-1:0] wrSlot, rdSlot;
  accessKind_t wrKind, rdKind;

  function automatic accessKind_t decodeKind(input logic [ADDR_W-1:0] a);
    int slot;
    slot = int'(a[ADDR_W-1:2]);
    if (slot < NUM_MREG) begin
      if (a[1:0] == 2'd0) return KIND_SET;
      if (a[1:0] == 2'd1) return KIND_CLR;
      return KIND_NONE;
    end
    if (slot < NUM_MREG + NUM_PREG && a[1:0] == 2'd0) return KIND_DIRECT;
    return KIND_NONE;
  endfunction

  always_comb begin
    wrKind   = decodeKind(wrAddr);
    wrSlot   = wrAddr[ADDR_W-1:2];
    wrHit    = (wrKind != KIND_NONE);
    wrIsPrio = (wrKind == KIND_DIRECT);
    wrRegIdx = wrIsPrio ? (wrSlot - SLOT_W'(NUM_MREG)) : wrSlot;
    oldVal   = '0;
    for (int i = 0; i < NUM_MREG; i++)
      if (int'(wrSlot) == i) oldVal = maskQ[i];
    for (int p = 0; p < NUM_PREG; p++)
      if (int'(wrSlot) == NUM_MREG + p) oldVal = prioQ[p];
    case (wrKind)
      KIND_SET:    nextVal = oldVal | wrData;
      KIND_CLR:    nextVal = oldVal & ~wrData;
      KIND_DIRECT: nextVal = wrData;
      default:     nextVal = oldVal;
    endcase
  end

  always_comb begin
    rdKind = decodeKind(rdAddr);
    rdSlot = rdAddr[ADDR_W-1:2];
    rdData = '0;
    if (rdKind != KIND_NONE) begin
      for (int i = 0; i < NUM_MREG; i++)
        if (int'(rdSlot) == i) rdData = maskQ[i];
      for (int p = 0; p < NUM_PREG; p++)
        if (int'(rdSlot) == NUM_MREG + p) rdData = prioQ[p];
    end
  end

  // Field k counts from the most significant end of the register.
  for (genvar k = 0; k < REG_W; k++) begin : g_field
    logic maskChg, maskOn;
    assign maskChg = oldVal[REG_W-1-k] ^ nextVal[REG_W-1-k];
    assign maskOn  = nextVal[REG_W-1-k];
    if (k < NPF) begin : g_prio
      logic [FIELD_W-1:0] oldF, newF;
      assign oldF = oldVal[(NPF-1-k)*FIELD_W +: FIELD_W];
      assign newF = nextVal[(NPF-1-k)*FIELD_W +: FIELD_W];
      assign changed[k] = wrIsPrio ? (oldF != newF) : maskChg;
      assign fieldOn[k] = wrIsPrio ? (newF != '0) : maskOn;
    end else begin : g_maskOnly
      assign changed[k] = wrIsPrio ? 1'b0 : maskChg;
      assign fieldOn[k] = wrIsPrio ? 1'b0 : maskOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MREG; i++) maskQ[i] <= '0;
      for (int p = 0; p < NUM_PREG; p++) prioQ[p] <= '0;
    end else if (ctl.commit) begin
      for (int i = 0; i < NUM_MREG; i++)
        if (int'(wrSlot) == i && !wrIsPrio) maskQ[i] <= nextVal;
      for (int p = 0; p < NUM_PREG; p++)
        if (int'(wrSlot) == NUM_MREG + p && wrIsPrio) prioQ[p] <= nextVal;
    end
  end

  for (genvar m = 0; m < NUM_MREG; m++) begin : g_maskChk
    p_set_keeps_r1: assert property (@(posedge clk) disable iff (!rstN)
      ctl.commit && wrAddr == ADDR_W'(4*m)
      |=> ((maskQ[m] & $past(maskQ[m])) == $past(maskQ[m])));
    p_clr_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
      ctl.commit && wrAddr == ADDR_W'(4*m+1)
      |=> ((maskQ[m] & $past(wrData)) == '0));
    p_hold_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.commit |=> $stable(maskQ[m]));
  end

  for (genvar p = 0; p < NUM_PREG; p++) begin : g_prioChk
    p_direct_r3: assert property (@(posedge clk) disable iff (!rstN)
      ctl.commit && wrAddr == ADDR_W'(4*(NUM_MREG+p))
      |=> (prioQ[p] == $past(wrData)));
    p_hold_prio_r9: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.commit |=> $stable(prioQ[p]));
  end

endmodule

// File: rtl/scmask_seq.sv
module scmask_seq
  import scmask_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int FIELD_W   = 4,
  parameter int NUM_MREG  = 2,
  parameter int NUM_PREG  = 1,
  parameter int ADDR_W    = 4,
  parameter int GROUP_LEN = 3,
  parameter int ID_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              dpHit,
  input  logic              dpIsPrio,
  input  logic [ADDR_W-3:0] dpRegIdx,
  input  logic [REG_W-1:0]  dpChanged,
  input  logic [REG_W-1:0]  dpFieldOn,
  output ctlStrobe_t        ctl,
  output logic              busy,
  output logic              evtValid,
  output logic              evtEnable,
  output logic [ID_W-1:0]   evtId
);

  localparam int NPF      = REG_W / FIELD_W;
  localparam int RSV_ID   = NUM_MREG * REG_W;
  localparam int GROUP_ID = NUM_MREG * REG_W + NUM_PREG * NPF;
  localparam int LAST_ID  = GROUP_ID + GROUP_LEN;
  localparam int SEL_W    = $clog2(REG_W);

  logic [REG_W-1:0]  pendQ, onQ;
  logic              isPrioQ, chainEnQ;
  logic [ADDR_W-3:0] regIdxQ;
  logic [ID_W-1:0]   chainIdQ, curId;
  logic [SEL_W-1:0]  sel;

  function automatic logic [ID_W-1:0] fieldId(input logic pr, input int idx, input int k);
    int id;
    if (!pr) begin
      id = idx * REG_W + k + 1;
      if (id == RSV_ID) id = 0;
    end else begin
      id = NUM_MREG * REG_W + idx * NPF + k + 1;
    end
    return ID_W'(id);
  endfunction

  function automatic logic [ID_W-1:0] nextId(input logic [ID_W-1:0] id);
    if (int'(id) >= GROUP_ID && int'(id) < LAST_ID) return id + 1'b1;
    return '0;
  endfunction

  always_comb begin
    sel = '0;
    for (int k = REG_W - 1; k >= 0; k--)
      if (pendQ[k]) sel = SEL_W'(k);
  end

  always_comb begin
    busy       = (pendQ != '0) || (chainIdQ != '0);
    ctl.commit = wrValid && !busy && dpHit;
    curId      = fieldId(isPrioQ, int'(regIdxQ), int'(sel));
    evtValid   = 1'b0;
    evtEnable  = 1'b0;
    evtId      = '0;
    if (chainIdQ != '0) begin
      evtValid  = 1'b1;
      evtEnable = chainEnQ;
      evtId     = chainIdQ;
    end else if (pendQ != '0 && curId != '0 && int'(curId) != GROUP_ID) begin
      evtValid  = 1'b1;
      evtEnable = onQ[sel];
      evtId     = curId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      onQ      <= '0;
      isPrioQ  <= 1'b0;
      regIdxQ  <= '0;
      chainIdQ <= '0;
      chainEnQ <= 1'b0;
    end else if (ctl.commit) begin
      pendQ    <= dpChanged;
      onQ      <= dpFieldOn;
      isPrioQ  <= dpIsPrio;
      regIdxQ  <= dpRegIdx;
      chainIdQ <= '0;
    end else if (chainIdQ != '0) begin
      chainIdQ <= nextId(chainIdQ);
    end else if (pendQ != '0) begin
      pendQ[sel] <= 1'b0;
      if (int'(curId) == GROUP_ID) begin
        chainIdQ <= nextId(curId);
        chainEnQ <= onQ[sel];
      end
    end
  end

  p_no_null_id_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtId != '0));

  p_chain_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && int'(evtId) > GROUP_ID && int'(evtId) < LAST_ID
    |=> evtValid && evtId == $past(evtId) + 1'b1 && evtEnable == $past(evtEnable));

  p_first_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit && dpChanged == '0 |=> !busy);

endmodule

// File: rtl/scmask_bank.sv
module scmask_bank
  import scmask_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int FIELD_W   = 4,
  parameter int NUM_MREG  = 2,
  parameter int NUM_PREG  = 1,
  parameter int ADDR_W    = 4,
  parameter int GROUP_LEN = 3,
  parameter int ID_W      = $clog2(NUM_MREG*REG_W + NUM_PREG*(REG_W/FIELD_W) + GROUP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              busy,
  output logic              evtValid,
  output logic              evtEnable,
  output logic [ID_W-1:0]   evtId
);

  ctlStrobe_t        ctl;
  logic              dpHit, dpIsPrio;
  logic [ADDR_W-3:0] dpRegIdx;
  logic [REG_W-1:0]  dpChanged, dpFieldOn;

  scmask_regs #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .NUM_MREG(NUM_MREG),
    .NUM_PREG(NUM_PREG), .ADDR_W(ADDR_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .wrHit(dpHit), .wrIsPrio(dpIsPrio), .wrRegIdx(dpRegIdx),
    .changed(dpChanged), .fieldOn(dpFieldOn)
  );

  scmask_seq #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .NUM_MREG(NUM_MREG),
    .NUM_PREG(NUM_PREG), .ADDR_W(ADDR_W), .GROUP_LEN(GROUP_LEN), .ID_W(ID_W)
  ) uSeq (
    .clk(clk), .rstN(rstN), .wrValid(wrValid),
    .dpHit(dpHit), .dpIsPrio(dpIsPrio), .dpRegIdx(dpRegIdx),
    .dpChanged(dpChanged), .dpFieldOn(dpFieldOn),
    .ctl(ctl), .busy(busy),
    .evtValid(evtValid), .evtEnable(evtEnable), .evtId(evtId)
  );

endmodule

// File: tb/scmask_bank_test.sv
`timescale 1ns/1ps
module scmask_bank_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       busy, evtValid, evtEnable;
  logic [4:0] evtId;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int evN;
  logic [4:0] evIds [32];
  logic       evEns [32];

  scmask_bank uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .evtValid(evtValid), .evtEnable(evtEnable), .evtId(evtId)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0] addr;
    logic [7:0] data;
    logic [7:0] expRd;
    logic [3:0] expCnt;
    logic [4:0] expId;
    logic       expEn;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 8'h81, 8'h81, 4'd2, 5'd1,  1'b1},  // R1 set
    '{4'h0, 8'h01, 8'h81, 4'd0, 5'd0,  1'b0},  // R6 no change
    '{4'h1, 8'h80, 8'h01, 4'd1, 5'd1,  1'b0},  // R2 clear, R4 read at clear addr
    '{4'h4, 8'h03, 8'h03, 4'd1, 5'd15, 1'b1},  // R8 reserved field silent
    '{4'h5, 8'h01, 8'h02, 4'd0, 5'd0,  1'b0},  // R8 reserved clear silent
    '{4'h8, 8'h50, 8'h50, 4'd1, 5'd17, 1'b1},  // R3 direct
    '{4'h8, 8'h30, 8'h30, 4'd1, 5'd17, 1'b1},  // R6 nonzero to nonzero
    '{4'h8, 8'h00, 8'h00, 4'd1, 5'd17, 1'b0},  // R6 to zero
    '{4'hC, 8'hFF, 8'h00, 4'd0, 5'd0,  1'b0},  // R4 unmapped
    '{4'h0, 8'h7E, 8'h7F, 4'd6, 5'd2,  1'b1}   // R5 field order
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive a write before the accepting edge, then record strobes until idle.
  task automatic writeAndCollect(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0;
    evN = 0;
    for (int guard = 0; guard < 40; guard++) begin
      if (evtValid) begin
        evIds[evN] = evtId; evEns[evN] = evtEnable; evN++;
      end
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++; testsRun++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int s = 0; s < 3; s++) begin
      rdAddr = 4'(4*s); #1;
      check(rdData == 8'h00, "R10 reset value", rdData, 0);
    end
    check(!busy && !evtValid, "R10 idle after reset", {busy, evtValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      writeAndCollect(VECS[i].addr, VECS[i].data);
      rdAddr = VECS[i].addr; #1;
      check(rdData == VECS[i].expRd, $sformatf("R1-R4 vec%0d readback", i), rdData, VECS[i].expRd);
      check(evN == int'(VECS[i].expCnt), $sformatf("R6 vec%0d strobe count", i), evN, VECS[i].expCnt);
      if (VECS[i].expCnt != 0 && evN > 0) begin
        check(evIds[0] == VECS[i].expId, $sformatf("R5 vec%0d first id", i), evIds[0], VECS[i].expId);
        check(evEns[0] == VECS[i].expEn, $sformatf("R6 vec%0d first enable", i), evEns[0], VECS[i].expEn);
      end
    end
    // R5 ascending order: last of vec9 is id 7
    check(evN == 6 && evIds[5] == 5'd7, "R5 last field id", evIds[5], 7);

    // R4 the clear address reads the same as the set address
    rdAddr = 4'h1; #1;
    check(rdData == 8'h7F, "R4 read at clear address", rdData, 8'h7F);

    // R7 group enable and disable chain
    writeAndCollect(4'h8, 8'h02);
    check(evN == 3, "R7 group enable count", evN, 3);
    for (int j = 0; j < 3 && j < evN; j++) begin
      check(evIds[j] == 5'(19 + j) && evEns[j], "R7 group enable member", evIds[j], 19 + j);
    end
    writeAndCollect(4'h8, 8'h00);
    check(evN == 3, "R7 group disable count", evN, 3);
    for (int j = 0; j < 3 && j < evN; j++) begin
      check(evIds[j] == 5'(19 + j) && !evEns[j], "R7 group disable member", evIds[j], 19 + j);
    end

    // R9 write while busy is ignored
    @(negedge clk);
    wrValid = 1'b1; wrAddr = 4'h1; wrData = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    check(busy, "R9 busy during walk", busy, 1);
    wrAddr = 4'h4; wrData = 8'hFF;
    evN = 0;
    if (evtValid) begin evIds[evN] = evtId; evEns[evN] = evtEnable; evN++; end
    @(negedge clk);
    wrValid = 1'b0;
    for (int guard = 0; guard < 40; guard++) begin
      if (evtValid) begin evIds[evN] = evtId; evEns[evN] = evtEnable; evN++; end
      if (!busy) break;
      @(negedge clk);
    end
    check(evN == 7, "R9 strobes of first write only", evN, 7);
    check(evIds[0] == 5'd2 && !evEns[0], "R2 clear first disable", evIds[0], 2);
    rdAddr = 4'h4; #1;
    check(rdData == 8'h02, "R9 blocked write left slot 1", rdData, 8'h02);
    rdAddr = 4'h0; #1;
    check(rdData == 8'h00, "R2 clear all", rdData, 0);

    // R9 a write after busy falls is taken
    writeAndCollect(4'h5, 8'h02);
    check(evN == 1 && evIds[0] == 5'd15 && !evEns[0], "R9 next write accepted", evIds[0], 15);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule